// File: doc/BRIEF.md
# NAND Controller Guarded Register Bank

This block is the software-visible register bank of a NAND flash controller. It holds the interface configuration and the bus timing word, and shields both behind a one-shot key. A key write opens exactly one protected write, after which the bank locks itself again. It also collects event pulses from the controller datapath into two places. One is a raw status word that tracks the current operation. The other is a latched interrupt status word that is cleared by reading it, and together with a mask it drives a single level interrupt line.

The bus side is a plain strobe port with a byte address. Reads are registered: data appears on `rdata_o` the cycle after `rd_en_i`, and any side effect of the read takes place on that same edge. Writing the value FFh to the command register performs a soft reset of the controller state. The pin engine and the ECC engine sit outside this block, and the configuration and timing words are passed out to them.

Top module: `nfc_regbank`

## Requirements
- R1: After reset, configuration, timing, interrupt mask, latched status and raw status all read zero, `irq_o` is low and the bank is locked.
- R2: Writing A25Eh (bits 15:0) to the key register (offset 0Ch) permits exactly one later write to configuration (04h) or timing (08h). A second protected write is ignored.
- R3: A write to configuration or timing while locked is ignored, and the register keeps its value.
- R4: Any write other than a correct key write relocks the bank. This includes a write to a non-protected register and a key write with a wrong value. Reads leave the lock state unchanged.
- R5: Configuration holds 4 bits (bit0 16-bit bus, bit1 long addressing, bit2 large-block page, bit3 write-protect enable), and timing holds 26 bits. Bits above these are dropped and read as zero.
- R6: Each event pulse sets its bit in latched status (offset 14h): bit0 write-protect fault, bit1 ECC ready, bit2 decode error, bit3 decode failure, bit4 controller ready, bit5 NAND ready.
- R7: A read of latched status returns its contents and clears it in the same access. An event arriving in the cycle of that read is not in the returned value, but it stays latched.
- R8: `irq_o` is high while any latched status bit is set together with its bit in the mask register (offset 10h, same bit layout).
- R9: Raw status (offset 18h) has bit0 NAND ready, bit1 controller ready, bit2 ECC ready, bit3 errors detected, bits5:4 the corrected count captured on a decode-error pulse, and bit6 decoder failure. Any command write (offset 00h) clears it.
- R10: A command write of FFh pulses `soft_rst_o` for one cycle, clears both status words and relocks the bank. Configuration, timing and mask are kept.
- R11: Read data appears in the cycle after the read strobe. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the access |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| ev_nand_rdy_i | input | 1 | NAND ready event pulse |
| ev_ctrl_rdy_i | input | 1 | Controller ready event pulse |
| ev_ecc_rdy_i | input | 1 | ECC ready event pulse |
| ev_dec_err_i | input | 1 | Correctable decode error event pulse |
| ev_dec_fail_i | input | 1 | Uncorrectable decode event pulse |
| ev_wp_fault_i | input | 1 | Write-protect fault event pulse |
| corr_cnt_i | input | CNT_W | Corrected symbols minus one, valid with decode error |
| cfg_o | output | 4 | Interface configuration word |
| timing_o | output | TIME_W | Bus timing word |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions check the following on every cycle: that a used unlock is gone after the protected write, that a non-key write leaves the bank locked, that a locked write leaves configuration unchanged, and that a clearing read with no new event empties the latched status. They also check that events are never lost from the latched status, that the corrected count is captured with its error pulse, and that a rising interrupt always has an event or a mask write behind it. Only the bench scenarios can show the bit positions seen from the bus and the value a read returns when an event arrives in the same cycle. The same holds for whether the soft reset keeps configuration and mask while clearing status, and for the exact one-write window of the key.

// File: rtl/nfc_reg_pkg.sv
package nfc_reg_pkg;
  localparam logic [7:0]  OFS_CMD   = 8'h00;
  localparam logic [7:0]  OFS_CFG   = 8'h04;
  localparam logic [7:0]  OFS_TIME  = 8'h08;
  localparam logic [7:0]  OFS_KEY   = 8'h0C;
  localparam logic [7:0]  OFS_IMASK = 8'h10;
  localparam logic [7:0]  OFS_ISTAT = 8'h14;
  localparam logic [7:0]  OFS_RAW   = 8'h18;

  localparam logic [15:0] UNLOCK_KEY   = 16'hA25E;
  localparam logic [7:0]  CMD_SOFT_RST = 8'hFF;

  localparam int unsigned NUM_EV = 6;
  localparam int unsigned EV_WP   = 0;
  localparam int unsigned EV_ECC  = 1;
  localparam int unsigned EV_DERR = 2;
  localparam int unsigned EV_DFAIL= 3;
  localparam int unsigned EV_CTRL = 4;
  localparam int unsigned EV_NAND = 5;

  typedef struct packed {
    logic wp_en;
    logic large_blk;
    logic long_addr;
    logic bus16;
  } cfg_t;
endpackage

// File: rtl/nfc_lock_guard.sv
module nfc_lock_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic key_sel_i,
  input  logic key_hit_i,
  input  logic prot_sel_i,
  input  logic soft_rst_i,
  output logic unlocked_o,
  output logic prot_we_o
);
  logic unlocked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          unlocked_q <= 1'b0;
    else if (soft_rst_i)  unlocked_q <= 1'b0;
    else if (wr_i)        unlocked_q <= key_sel_i && key_hit_i;
  end

  assign unlocked_o = unlocked_q;
  assign prot_we_o  = wr_i && prot_sel_i && unlocked_q;

  // one protected write consumes the unlock
  assert_single_use_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && prot_sel_i && unlocked_q) |=> !unlocked_q);

  assert_relock_other_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !key_sel_i) |=> !unlocked_q);

  assert_read_keeps_lock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !soft_rst_i) |=> $stable(unlocked_q));
endmodule

// File: rtl/nfc_irq_ctrl.sv
module nfc_irq_ctrl #(
  parameter int unsigned NUM_EV = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic              mask_we_i,
  input  logic [NUM_EV-1:0] mask_wdata_i,
  input  logic              clr_i,
  input  logic              soft_rst_i,
  output logic [NUM_EV-1:0] stat_o,
  output logic [NUM_EV-1:0] mask_o,
  output logic              irq_o
);
  logic [NUM_EV-1:0] stat_q, mask_q, stat_base;

  // clear and new events in one cycle: events win
  assign stat_base = (clr_i || soft_rst_i) ? '0 : stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_base | ev_i;
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & mask_q);

  assert_clear_on_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && (ev_i == '0)) |=> (stat_q == '0));

  assert_event_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i != '0) |=> ((stat_q & $past(ev_i)) == $past(ev_i)));

  assert_irq_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(ev_i != '0) || $past(mask_we_i)));
endmodule

// File: rtl/nfc_raw_status.sv
module nfc_raw_status #(
  parameter int unsigned CNT_W = 2,
  localparam int unsigned RAW_W = CNT_W + 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             nand_rdy_i,
  input  logic             ctrl_rdy_i,
  input  logic             ecc_rdy_i,
  input  logic             dec_err_i,
  input  logic             dec_fail_i,
  input  logic [CNT_W-1:0] corr_cnt_i,
  output logic [RAW_W-1:0] raw_o
);
  localparam int unsigned CNT_LO  = 4;
  localparam int unsigned FAIL_B  = CNT_LO + CNT_W;

  logic             nand_q, ctrl_q, ecc_q, err_q, fail_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {nand_q, ctrl_q, ecc_q, err_q, fail_q} <= '0;
      cnt_q <= '0;
    end else begin
      nand_q <= nand_rdy_i || (!clr_i && nand_q);
      ctrl_q <= ctrl_rdy_i || (!clr_i && ctrl_q);
      ecc_q  <= ecc_rdy_i  || (!clr_i && ecc_q);
      err_q  <= dec_err_i  || (!clr_i && err_q);
      fail_q <= dec_fail_i || (!clr_i && fail_q);
      if (dec_err_i)  cnt_q <= corr_cnt_i;
      else if (clr_i) cnt_q <= '0;
    end
  end

  always_comb begin
    raw_o = '0;
    raw_o[0] = nand_q;
    raw_o[1] = ctrl_q;
    raw_o[2] = ecc_q;
    raw_o[3] = err_q;
    raw_o[CNT_LO +: CNT_W] = cnt_q;
    raw_o[FAIL_B] = fail_q;
  end

  assert_cnt_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_err_i |=> (raw_o[CNT_LO +: CNT_W] == $past(corr_cnt_i)) && raw_o[3]);

  assert_raw_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !nand_rdy_i && !ctrl_rdy_i && !ecc_rdy_i && !dec_err_i && !dec_fail_i)
      |=> (raw_o == '0));
endmodule

// File: rtl/nfc_regbank.sv
module nfc_regbank
  import nfc_reg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TIME_W = 26,
  parameter int unsigned CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ev_nand_rdy_i,
  input  logic              ev_ctrl_rdy_i,
  input  logic              ev_ecc_rdy_i,
  input  logic              ev_dec_err_i,
  input  logic              ev_dec_fail_i,
  input  logic              ev_wp_fault_i,
  input  logic [CNT_W-1:0]  corr_cnt_i,
  output logic [3:0]        cfg_o,
  output logic [TIME_W-1:0] timing_o,
  output logic              soft_rst_o,
  output logic              irq_o
);
  localparam int unsigned RAW_W = CNT_W + 5;
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_TIME  = ADDR_W'(OFS_TIME);
  localparam logic [ADDR_W-1:0] A_KEY   = ADDR_W'(OFS_KEY);
  localparam logic [ADDR_W-1:0] A_IMASK = ADDR_W'(OFS_IMASK);
  localparam logic [ADDR_W-1:0] A_ISTAT = ADDR_W'(OFS_ISTAT);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFS_RAW);

  logic              sel_cmd, sel_cfg, sel_time, sel_key, sel_mask, sel_stat, sel_raw;
  logic              cmd_we, soft_rst, prot_we, unlocked;
  cfg_t              cfg_q;
  logic [TIME_W-1:0] time_q;
  logic              soft_rst_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic [NUM_EV-1:0] ev_vec, stat, mask;
  logic [RAW_W-1:0]  raw;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;

  assign sel_cmd  = (addr_i == A_CMD);
  assign sel_cfg  = (addr_i == A_CFG);
  assign sel_time = (addr_i == A_TIME);
  assign sel_key  = (addr_i == A_KEY);
  assign sel_mask = (addr_i == A_IMASK);
  assign sel_stat = (addr_i == A_ISTAT);
  assign sel_raw  = (addr_i == A_RAW);

  assign cmd_we   = wr_en_i && sel_cmd;
  assign soft_rst = cmd_we && (wdata_i[7:0] == CMD_SOFT_RST);

  always_comb begin
    ev_vec           = '0;
    ev_vec[EV_WP]    = ev_wp_fault_i;
    ev_vec[EV_ECC]   = ev_ecc_rdy_i;
    ev_vec[EV_DERR]  = ev_dec_err_i;
    ev_vec[EV_DFAIL] = ev_dec_fail_i;
    ev_vec[EV_CTRL]  = ev_ctrl_rdy_i;
    ev_vec[EV_NAND]  = ev_nand_rdy_i;
  end

  nfc_lock_guard u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_en_i),
    .key_sel_i  (sel_key),
    .key_hit_i  (wdata_i[15:0] == UNLOCK_KEY),
    .prot_sel_i (sel_cfg || sel_time),
    .soft_rst_i (soft_rst),
    .unlocked_o (unlocked),
    .prot_we_o  (prot_we)
  );

  nfc_irq_ctrl #(.NUM_EV(NUM_EV)) u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ev_i         (ev_vec),
    .mask_we_i    (wr_en_i && sel_mask),
    .mask_wdata_i (wdata_i[NUM_EV-1:0]),
    .clr_i        (rd_en_i && sel_stat),
    .soft_rst_i   (soft_rst),
    .stat_o       (stat),
    .mask_o       (mask),
    .irq_o        (irq_o)
  );

  nfc_raw_status #(.CNT_W(CNT_W)) u_raw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cmd_we),
    .nand_rdy_i (ev_nand_rdy_i),
    .ctrl_rdy_i (ev_ctrl_rdy_i),
    .ecc_rdy_i  (ev_ecc_rdy_i),
    .dec_err_i  (ev_dec_err_i),
    .dec_fail_i (ev_dec_fail_i),
    .corr_cnt_i (corr_cnt_i),
    .raw_o      (raw)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '0;
      time_q     <= '0;
      soft_rst_q <= 1'b0;
    end else begin
      soft_rst_q <= soft_rst;
      if (prot_we && sel_cfg)  cfg_q  <= cfg_t'(wdata_i[3:0]);
      if (prot_we && sel_time) time_q <= wdata_i[TIME_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      sel_cfg:  rd_mux = DATA_W'(cfg_q);
      sel_time: rd_mux = DATA_W'(time_q);
      sel_mask: rd_mux = DATA_W'(mask);
      sel_stat: rd_mux = DATA_W'(stat);
      sel_raw:  rd_mux = DATA_W'(raw);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
    else              rdata_q <= '0;
  end

  assign rdata_o    = rdata_q;
  assign cfg_o      = cfg_q;
  assign timing_o   = time_q;
  assign soft_rst_o = soft_rst_q;

  assert_locked_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (sel_cfg || sel_time) && !unlocked) |=> ($stable(cfg_o) && $stable(timing_o)));

  assert_soft_rst_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (soft_rst_o && !unlocked && $stable(cfg_o)));

  assert_soft_rst_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o || $past(soft_rst));
endmodule

// File: tb/tb_nfc_regbank.sv
module tb_nfc_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  ev = '0;   // bit order as latched status
  logic [1:0]  corr = '0;
  logic [3:0]  cfg;
  logic [25:0] timing;
  logic        soft_rst, irq;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  nfc_regbank dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata),
    .ev_nand_rdy_i(ev[5]), .ev_ctrl_rdy_i(ev[4]), .ev_ecc_rdy_i(ev[1]),
    .ev_dec_err_i(ev[2]), .ev_dec_fail_i(ev[3]), .ev_wp_fault_i(ev[0]),
    .corr_cnt_i(corr), .cfg_o(cfg), .timing_o(timing), .soft_rst_o(soft_rst), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [5:0] e);
    @(negedge clk); ev = e;
    @(negedge clk); ev = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 cfg_o", 32'(cfg), 0);
    check("R1 irq_o", 32'(irq), 0);
    rd(8'h04, d); check("R1 cfg", d, 0);
    rd(8'h08, d); check("R1 timing", d, 0);
    rd(8'h10, d); check("R1 mask", d, 0);
    rd(8'h14, d); check("R1 istat", d, 0);
    rd(8'h18, d); check("R1 raw", d, 0);
  endtask

  task automatic t_locked;
    logic [31:0] d;
    wr(8'h04, 32'hF);
    rd(8'h04, d); check("R3 locked cfg write", d, 0);
    wr(8'h08, 32'h123);
    check("R3 locked timing write", 32'(timing), 0);
  endtask

  task automatic t_unlock;
    logic [31:0] d;
    wr(8'h0C, 32'hA25E);
    wr(8'h04, 32'h6);
    check("R2 unlocked cfg write", 32'(cfg), 32'h6);
    wr(8'h04, 32'hF);
    rd(8'h04, d); check("R2 second write ignored", d, 32'h6);
    wr(8'h0C, 32'hA25E);
    wr(8'h04, 32'hFFFF_FFF1);
    rd(8'h04, d); check("R5 cfg width", d, 32'h1);
    wr(8'h0C, 32'hA25E);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); check("R5 timing width", d, 32'h03FF_FFFF);
  endtask

  task automatic t_relock;
    logic [31:0] d;
    wr(8'h0C, 32'hA25E);
    wr(8'h10, 32'h0);
    wr(8'h04, 32'h8);
    rd(8'h04, d); check("R4 relock by mask write", d, 32'h1);
    wr(8'h0C, 32'h1234);
    wr(8'h08, 32'h55);
    rd(8'h08, d); check("R4 wrong key", d, 32'h03FF_FFFF);
    wr(8'h0C, 32'hA25E);
    rd(8'h18, d);
    wr(8'h04, 32'hA);
    rd(8'h04, d); check("R4 read keeps unlock", d, 32'hA);
  endtask

  task automatic t_events;
    logic [31:0] d;
    for (int i = 0; i < 6; i++) begin
      pulse(6'(1 << i));
      rd(8'h14, d); check("R6 event bit", d, 32'(1 << i));
      rd(8'h14, d); check("R7 cleared by read", d, 0);
    end
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    pulse(6'h20);
    @(negedge clk); addr = 8'h14; rd_en = 1'b1; ev = 6'h10;
    @(negedge clk); rd_en = 1'b0; ev = '0; d = rdata;
    check("R7 read during event", d, 32'h20);
    rd(8'h14, d); check("R7 event kept", d, 32'h10);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    pulse(6'h02);
    check("R8 masked off", 32'(irq), 0);
    wr(8'h10, 32'h02);
    check("R8 unmasked", 32'(irq), 1);
    rd(8'h14, d);
    check("R8 low after clear", 32'(irq), 0);
    pulse(6'h01);
    check("R8 other bit masked", 32'(irq), 0);
    rd(8'h14, d);
  endtask

  task automatic t_raw;
    logic [31:0] d;
    wr(8'h00, 32'h0);
    corr = 2'd2;
    pulse(6'h20); pulse(6'h10); pulse(6'h02); pulse(6'h04); pulse(6'h08);
    corr = 2'd0;
    rd(8'h18, d); check("R9 raw layout", d, 32'h6F);
    wr(8'h00, 32'h30);
    rd(8'h18, d); check("R9 cleared by command", d, 0);
    rd(8'h14, d);
  endtask

  task automatic t_softrst;
    logic [31:0] d;
    wr(8'h10, 32'h3F);
    pulse(6'h01);
    check("R8 irq before soft reset", 32'(irq), 1);
    wr(8'h0C, 32'hA25E);
    wr(8'h00, 32'hFF);
    check("R10 pulse high", 32'(soft_rst), 1);
    @(negedge clk);
    check("R10 pulse one cycle", 32'(soft_rst), 0);
    check("R10 irq cleared", 32'(irq), 0);
    rd(8'h14, d); check("R10 istat cleared", d, 0);
    rd(8'h10, d); check("R10 mask kept", d, 32'h3F);
    wr(8'h04, 32'h3);
    rd(8'h04, d); check("R10 relocked, cfg kept", d, 32'hA);
  endtask

  task automatic t_readpath;
    logic [31:0] d;
    rd(8'h40, d); check("R11 unmapped", d, 0);
    @(negedge clk); addr = 8'h04; rd_en = 1'b1;
    #1 check("R11 not yet visible", rdata, 0);
    @(negedge clk); rd_en = 1'b0;
    check("R11 next cycle", rdata, 32'hA);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_locked();
    t_unlock();
    t_relock();
    t_events();
    t_same_cycle();
    t_irq();
    t_raw();
    t_softrst();
    t_readpath();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule